// File: doc/BRIEF.md
# Two-Level Interrupt Priority Controller

This block sits beside a small 8-bit processor core and decides which of five interrupt sources the core takes next. There are two active-low external request pins, two timer overflow strobes and a serial port whose receive and transmit flags share one request. Software sets up the block through two byte-wide registers on a special-function-register bus. The enable register holds one bit per source plus a master bit. The level register places each source in the high or the low group.

Requests are caught and held even while they are masked. The arbiter takes an eligible high-group request before any low-group one. Inside a group, the fixed polling order picks the winner. The block keeps one in-service bit per group, so a low-group handler can be cut short only by a high-group request, and a high-group handler by nothing. A return pulse from the core clears the deepest in-service level.

The chosen request goes to the core over a valid/ready pair that carries a handler vector. Once `irq_valid` rises, the vector and valid stay frozen until the core accepts with `irq_ready`, even if a more urgent request turns up meanwhile. That request waits for the next offer. While `irq_valid` is low, `irq_ready` is ignored. The accept cycle acknowledges the source.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Right after reset, `irq_valid` is low and `irq_vector` reads 0x0000 (the program-start address), and both registers read zero.
- R2: The enable register sits at address 0xA8. Bits 0..4 enable external 0, timer 0, external 1, timer 1 and serial, and bit 7 is the master enable. The level register sits at 0xB8, with bits 0..4 in the same source order, where 1 means high group. Unused bits, and any other address, read as zero.
- R3: A falling edge on an `ext_n` pin, or a one-cycle `tmr_ovf` strobe, sets a request flag. The flag stays set while masked and is offered once it is enabled.
- R4: With the master bit clear no request is offered; with a source's own enable bit clear that source is not offered.
- R5: An eligible high-group request wins over any low-group request, whatever their polling positions.
- R6: Within one group the winner is the first pending source in the order external 0, timer 0, external 1, timer 1, serial.
- R7: The offered vector is 0x0003, 0x000B, 0x0013, 0x001B or 0x0023 for external 0, timer 0, external 1, timer 1 and serial.
- R8: A high-group request is offered only while no high-group handler is in service. A low-group request is offered only while no handler of either group is in service.
- R9: A `reti` pulse clears the high in-service bit if it is set, otherwise the low one.
- R10: Acceptance clears the external and timer flags of the accepted source. The serial request follows `ser_ri | ser_ti` and is not cleared by acceptance.
- R11: While `irq_valid` is high and `irq_ready` is low, `irq_valid` and `irq_vector` hold their values. A cycle with both high is the acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_we | input | 1 | Register bus write strobe |
| sfr_rdata | output | 8 | Register bus read data (combinational on address) |
| ext_n | input | NPAIR (2) | Active-low external request pins; bit 0 is external 0 |
| tmr_ovf | input | NPAIR (2) | Timer overflow strobes; bit 0 is timer 0 |
| ser_ri | input | 1 | Serial receive flag |
| ser_ti | input | 1 | Serial transmit flag |
| irq_valid | output | 1 | An interrupt is offered to the core |
| irq_ready | input | 1 | Core accepts the offer |
| irq_vector | output | 16 | Handler address of the offer; 0x0000 when idle |
| reti | input | 1 | Core returns from a handler |

## Verification
The bench fires several sources in the same cycle. It checks that grants come out in polling order when all sources are low group, and high-group first otherwise. A wrong priority encoder would show up as a swapped vector in the scoreboard. It nests a high-group external request inside a low-group timer handler, then issues returns one at a time. A controller that cleared the wrong in-service bit, or let a low request pre-empt, would offer too early. The bench also holds back `irq_ready` while a more urgent request arrives, so a design that re-arbitrates a pending offer would change the vector. It checks that the serial request survives acceptance while the timer flags do not, and that requests raised while masked come out once they are enabled rather than being lost.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  localparam logic [7:0] ADDR_ENABLE = 8'hA8;
  localparam logic [7:0] ADDR_LEVEL  = 8'hB8;
  localparam int         MASTER_BIT  = 7;

  // handler address for a source index: 3 + 8*idx
  function automatic logic [15:0] vec_of(input logic [7:0] idx);
    return 16'h0003 + {5'b00000, idx, 3'b000};
  endfunction

endpackage

// File: rtl/irq_sfr_regs.sv
module irq_sfr_regs #(
  parameter int NS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    sfr_addr,
  input  logic [7:0]    sfr_wdata,
  input  logic          sfr_we,
  output logic [7:0]    sfr_rdata,
  output logic [NS-1:0] src_en,
  output logic          glb_en,
  output logic [NS-1:0] src_hi
);
  import irq_prio_pkg::*;

  localparam logic [7:0] SRC_MASK = 8'((1 << NS) - 1);
  localparam logic [7:0] EN_MASK  = SRC_MASK | 8'(1 << MASTER_BIT);

  logic [7:0] en_q;
  logic [7:0] lv_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
      lv_q <= '0;
    end else if (sfr_we) begin
      case (sfr_addr)
        ADDR_ENABLE: en_q <= sfr_wdata & EN_MASK;
        ADDR_LEVEL:  lv_q <= sfr_wdata & SRC_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sfr_addr)
      ADDR_ENABLE: sfr_rdata = en_q;
      ADDR_LEVEL:  sfr_rdata = lv_q;
      default:     sfr_rdata = 8'h00;
    endcase
  end

  assign src_en = en_q[NS-1:0];
  assign glb_en = en_q[MASTER_BIT];
  assign src_hi = lv_q[NS-1:0];

  // R2: a write to another address leaves both registers unchanged
  a_r2_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && sfr_addr != ADDR_ENABLE && sfr_addr != ADDR_LEVEL)
      |=> ($stable(en_q) && $stable(lv_q)));

endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int NPAIR = 2,
  localparam int NS   = 2 * NPAIR + 1,
  localparam int SW   = $clog2(NS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPAIR-1:0] ext_n,
  input  logic [NPAIR-1:0] tmr_ovf,
  input  logic             ser_ri,
  input  logic             ser_ti,
  input  logic             ack,
  input  logic [SW-1:0]    ack_src,
  output logic [NS-1:0]    pend
);

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    logic ext_prev;
    logic ext_flag;
    logic tmr_flag;
    logic ext_fall;
    logic ext_clr;
    logic tmr_clr;

    assign ext_fall = ext_prev & ~ext_n[k];
    assign ext_clr  = ack && (ack_src == SW'(2 * k));
    assign tmr_clr  = ack && (ack_src == SW'(2 * k + 1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ext_prev <= 1'b1;
        ext_flag <= 1'b0;
        tmr_flag <= 1'b0;
      end else begin
        ext_prev <= ext_n[k];
        ext_flag <= ext_fall   | (ext_flag & ~ext_clr);
        tmr_flag <= tmr_ovf[k] | (tmr_flag & ~tmr_clr);
      end
    end

    assign pend[2 * k]     = ext_flag;
    assign pend[2 * k + 1] = tmr_flag;

    // R10: accepted timer request is cleared unless a new strobe arrives
    a_r10_tmr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_clr && !tmr_ovf[k]) |=> !pend[2 * k + 1]);

    // R3: a strobe always leaves the flag set
    a_r3_tmr_capture: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf[k] |=> pend[2 * k + 1]);
  end

  logic ser_q;
  always_ff @(posedge clk) begin
    if (!rst_n) ser_q <= 1'b0;
    else        ser_q <= ser_ri | ser_ti;
  end
  assign pend[NS-1] = ser_q;

  // R10: serial request survives acceptance while the port flags stay up
  a_r10_ser_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_ri || ser_ti) |=> pend[NS-1]);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int  NS = 5,
  localparam int SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] pend,
  input  logic [NS-1:0] src_en,
  input  logic          glb_en,
  input  logic [NS-1:0] src_hi,
  output logic          win_vld,
  output logic [SW-1:0] win_src,
  output logic          win_lvl
);

  logic [NS-1:0] elig;
  logic [NS-1:0] hi_req;
  logic [NS-1:0] lo_req;

  assign elig   = pend & src_en & {NS{glb_en}};
  assign hi_req = elig & src_hi;
  assign lo_req = elig & ~src_hi;

  // descending scans leave the lowest index; high group overrides low
  always_comb begin
    win_vld = 1'b0;
    win_src = '0;
    win_lvl = 1'b0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (lo_req[i]) begin
        win_vld = 1'b1;
        win_src = SW'(i);
        win_lvl = 1'b0;
      end
    end
    for (int i = NS - 1; i >= 0; i--) begin
      if (hi_req[i]) begin
        win_vld = 1'b1;
        win_src = SW'(i);
        win_lvl = 1'b1;
      end
    end
  end

  // R5: any eligible high request puts the winner in the high group
  a_r5_high_first: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend & src_en & src_hi) && glb_en) |-> (win_vld && win_lvl));

  // R4: the winner is always pending and enabled
  a_r4_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> (pend[win_src] && src_en[win_src] && glb_en));

endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track #(
  parameter int  NS = 5,
  localparam int SW = $clog2(NS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_vld,
  input  logic [SW-1:0] win_src,
  input  logic          win_lvl,
  input  logic          irq_ready,
  input  logic          reti,
  output logic          irq_valid,
  output logic [15:0]   irq_vector,
  output logic          ack,
  output logic [SW-1:0] ack_src
);
  import irq_prio_pkg::*;

  logic          valid_q;
  logic [SW-1:0] src_q;
  logic          lvl_q;
  logic [1:0]    in_svc;
  logic [1:0]    svc_clr;
  logic [1:0]    svc_set;
  logic          take;
  logic          allowed;

  assign take    = valid_q & irq_ready;
  assign allowed = win_lvl ? !in_svc[1] : (in_svc == 2'b00);

  always_comb begin
    svc_clr = 2'b00;
    if (reti) begin
      if (in_svc[1])      svc_clr = 2'b10;
      else if (in_svc[0]) svc_clr = 2'b01;
    end
    svc_set = 2'b00;
    if (take) svc_set = lvl_q ? 2'b10 : 2'b01;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      src_q   <= '0;
      lvl_q   <= 1'b0;
      in_svc  <= 2'b00;
    end else begin
      if (valid_q) begin
        if (irq_ready) valid_q <= 1'b0;
      end else if (win_vld && allowed) begin
        valid_q <= 1'b1;
        src_q   <= win_src;
        lvl_q   <= win_lvl;
      end
      in_svc <= (in_svc & ~svc_clr) | svc_set;
    end
  end

  assign irq_valid  = valid_q;
  assign irq_vector = valid_q ? vec_of(8'(src_q)) : 16'h0000;
  assign ack        = take;
  assign ack_src    = src_q;

  // R11: an offer is frozen until accepted
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=> (irq_valid && $stable(irq_vector)));

  // R8: no offer while a high handler runs; low offers only when idle
  a_r8_nest_high: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !in_svc[1]);
  a_r8_nest_low: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !lvl_q) |-> (in_svc == 2'b00));

  // R9: a return pulse drops exactly one in-service level
  a_r9_reti_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take && in_svc != 2'b00)
      |=> ($countones(in_svc) == $countones($past(in_svc)) - 1));

  // R7: offered vectors lie on the 8-byte handler grid
  a_r7_vec_grid: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector[2:0] == 3'b011 && irq_vector <= vec_of(8'(NS - 1))));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int  NPAIR = 2,
  localparam int NS    = 2 * NPAIR + 1,
  localparam int SW    = $clog2(NS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       sfr_addr,
  input  logic [7:0]       sfr_wdata,
  input  logic             sfr_we,
  output logic [7:0]       sfr_rdata,
  input  logic [NPAIR-1:0] ext_n,
  input  logic [NPAIR-1:0] tmr_ovf,
  input  logic             ser_ri,
  input  logic             ser_ti,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [15:0]      irq_vector,
  input  logic             reti
);

  logic [NS-1:0] src_en;
  logic [NS-1:0] src_hi;
  logic          glb_en;
  logic [NS-1:0] pend;
  logic          win_vld;
  logic [SW-1:0] win_src;
  logic          win_lvl;
  logic          ack;
  logic [SW-1:0] ack_src;

  irq_sfr_regs #(.NS(NS)) i_regs (
    .clk(clk), .rst_n(rst_n),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_we(sfr_we),
    .sfr_rdata(sfr_rdata),
    .src_en(src_en), .glb_en(glb_en), .src_hi(src_hi)
  );

  irq_req_latch #(.NPAIR(NPAIR)) i_latch (
    .clk(clk), .rst_n(rst_n),
    .ext_n(ext_n), .tmr_ovf(tmr_ovf),
    .ser_ri(ser_ri), .ser_ti(ser_ti),
    .ack(ack), .ack_src(ack_src),
    .pend(pend)
  );

  irq_arbiter #(.NS(NS)) i_arb (
    .clk(clk), .rst_n(rst_n),
    .pend(pend), .src_en(src_en), .glb_en(glb_en), .src_hi(src_hi),
    .win_vld(win_vld), .win_src(win_src), .win_lvl(win_lvl)
  );

  irq_nest_track #(.NS(NS)) i_nest (
    .clk(clk), .rst_n(rst_n),
    .win_vld(win_vld), .win_src(win_src), .win_lvl(win_lvl),
    .irq_ready(irq_ready), .reti(reti),
    .irq_valid(irq_valid), .irq_vector(irq_vector),
    .ack(ack), .ack_src(ack_src)
  );

  // R4: a fresh offer only follows a cycle with the master bit set
  a_r4_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_valid) |-> $past(glb_en));

endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  sfr_addr = 8'h00;
  logic [7:0]  sfr_wdata = 8'h00;
  logic        sfr_we = 1'b0;
  logic [7:0]  sfr_rdata;
  logic [1:0]  ext_n = 2'b11;
  logic [1:0]  tmr_ovf = 2'b00;
  logic        ser_ri = 1'b0;
  logic        ser_ti = 1'b0;
  logic        irq_valid;
  logic        irq_ready = 1'b0;
  logic [15:0] irq_vector;
  logic        reti = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_we(sfr_we),
    .sfr_rdata(sfr_rdata),
    .ext_n(ext_n), .tmr_ovf(tmr_ovf), .ser_ri(ser_ri), .ser_ti(ser_ti),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_vector(irq_vector),
    .reti(reti)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // monitor: pops expected vectors at each acceptance
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && irq_valid && irq_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11", "unexpected grant", int'(irq_vector), 0);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(irq_vector == e, t, "granted vector", int'(irq_vector), int'(e));
        end
      end
    end
  end

  task automatic reg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
    @(negedge clk);
    sfr_we = 1'b0;
  endtask

  task automatic reg_chk(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    sfr_addr = a;
    #2;
    chk(sfr_rdata == e, tag, "register read", int'(sfr_rdata), int'(e));
  endtask

  task automatic tmr_pulse(input logic [1:0] m);
    @(negedge clk); tmr_ovf = m;
    @(negedge clk); tmr_ovf = 2'b00;
  endtask

  task automatic ext_pulse(input logic [1:0] m);
    @(negedge clk); ext_n = ext_n & ~m;
    @(negedge clk);
    @(negedge clk); ext_n = ext_n | m;
  endtask

  task automatic do_reti();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  task automatic no_offer(input int n, input string tag);
    bit ok = 1'b1;
    repeat (n) begin
      @(negedge clk); #2;
      if (irq_valid) ok = 1'b0;
    end
    chk(ok, tag, "offer while blocked", int'(irq_valid), 0);
  endtask

  // driver: push expectation, wait for offer, accept it
  task automatic grant(input logic [15:0] v, input string tag);
    bit seen = 1'b0;
    exp_q.push_back(v);
    tag_q.push_back(tag);
    for (int i = 0; i < 20 && !seen; i++) begin
      @(negedge clk); #2;
      seen = irq_valid;
    end
    if (!seen) begin
      void'(exp_q.pop_back());
      void'(tag_q.pop_back());
      chk(1'b0, tag, "no offer", 0, int'(v));
    end else begin
      @(negedge clk); irq_ready = 1'b1;
      @(negedge clk); irq_ready = 1'b0;
    end
  endtask

  initial begin
    #(8 * 100000);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #2;
    chk(!irq_valid, "R1", "valid in reset", int'(irq_valid), 0);
    chk(irq_vector == 16'h0000, "R1", "vector in reset", int'(irq_vector), 0);
    @(negedge clk); rst_n = 1'b1;
    reg_chk(8'hA8, 8'h00, "R1");
    reg_chk(8'hB8, 8'h00, "R1");

    // R2: readback masks
    reg_wr(8'hA8, 8'hFF);
    reg_chk(8'hA8, 8'h9F, "R2");
    reg_wr(8'hB8, 8'hFF);
    reg_chk(8'hB8, 8'h1F, "R2");
    reg_chk(8'h80, 8'h00, "R2");
    reg_wr(8'hA8, 8'h00);
    reg_wr(8'hB8, 8'h00);

    // R4 / R3: masked request held, then served
    tmr_pulse(2'b01);
    no_offer(6, "R4");
    reg_wr(8'hA8, 8'h02);
    no_offer(4, "R4");
    reg_wr(8'hA8, 8'h82);
    grant(16'h000B, "R3");
    do_reti();

    // R4: per-source enable
    reg_wr(8'hA8, 8'h81);
    tmr_pulse(2'b10);
    no_offer(6, "R4");
    reg_wr(8'hA8, 8'h89);
    grant(16'h001B, "R3");
    do_reti();

    // R6 / R7: all low group, everything at once
    reg_wr(8'hA8, 8'h9F);
    @(negedge clk);
    tmr_ovf = 2'b11; ext_n = 2'b00; ser_ri = 1'b1;
    @(negedge clk);
    tmr_ovf = 2'b00;
    @(negedge clk);
    ext_n = 2'b11;
    grant(16'h0003, "R6"); do_reti();
    grant(16'h000B, "R6"); do_reti();
    grant(16'h0013, "R7"); do_reti();
    grant(16'h001B, "R7"); do_reti();
    grant(16'h0023, "R7"); do_reti();
    // R10: serial stays pending, timers did not come back
    grant(16'h0023, "R10");
    @(negedge clk); ser_ri = 1'b0;
    do_reti();
    no_offer(6, "R10");

    // R5: high group beats earlier polling position
    reg_wr(8'hB8, 8'h08);
    @(negedge clk); tmr_ovf = 2'b10; ext_n = 2'b10;
    @(negedge clk); tmr_ovf = 2'b00;
    @(negedge clk); ext_n = 2'b11;
    grant(16'h001B, "R5"); do_reti();
    grant(16'h0003, "R5"); do_reti();

    // R8 / R9: nesting
    reg_wr(8'hB8, 8'h04);
    tmr_pulse(2'b01);
    grant(16'h000B, "R8");
    tmr_pulse(2'b10);
    no_offer(6, "R8");
    ext_pulse(2'b10);
    grant(16'h0013, "R8");
    ext_pulse(2'b01);
    no_offer(4, "R8");
    do_reti();
    no_offer(6, "R9");
    do_reti();
    grant(16'h0003, "R9"); do_reti();
    grant(16'h001B, "R9"); do_reti();

    // R8: high cannot pre-empt high
    reg_wr(8'hB8, 8'h03);
    ext_pulse(2'b01);
    grant(16'h0003, "R8");
    tmr_pulse(2'b01);
    no_offer(6, "R8");
    do_reti();
    grant(16'h000B, "R8"); do_reti();

    // R11: back-pressure holds the offer
    reg_wr(8'hB8, 8'h00);
    tmr_pulse(2'b10);
    begin
      bit ok = 1'b1;
      repeat (3) @(negedge clk);
      ext_pulse(2'b01);
      repeat (4) begin
        @(negedge clk); #2;
        if (!irq_valid || irq_vector != 16'h001B) ok = 1'b0;
      end
      chk(ok, "R11", "held offer", int'(irq_vector), 16'h001B);
    end
    grant(16'h001B, "R11"); do_reti();
    grant(16'h0003, "R6"); do_reti();
    no_offer(4, "R10");

    chk(exp_q.size() == 0, "R11", "leftover expectations", exp_q.size(), 0);
    summary();
    $finish;
  end

endmodule